// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. Software drives it through four bus addresses. It places a channel number, a sampling strobe and a trial code on the analog side, and it reads back one comparator bit each clock. Writing a channel number to the start address begins a conversion. The sequencer first holds the sampling strobe for a programmed number of cycles. It then runs a binary search from the most significant bit down, and at the end copies the code into a result register.

The result register is separate from the search register. A bus read of the result returns the last finished code at any time, including while a new conversion runs. The rules for stopping a conversion depend on the address written. A start write always restarts. A write to the control or pin-enable address stops the conversion and starts nothing. The two highest channel codes select the low and high reference. For these channels the sampling phase is skipped and the search starts at once.

Top module: `sar_seq`

## Requirements
- R1: A bus write to address 0 loads the channel from the low CW bits of the write data onto `ch_sel`, sets `busy` on the next cycle and clears `done`.
- R2: A write to address 0 while a conversion runs abandons that conversion and starts a new one on the newly written channel. The timing is counted from the new write, and the result is that of the new channel.
- R3: A write to address 1 stores write data bits [1:0] as the sample-length select and stops any running conversion: `busy` and `samp_en` are low on the next cycle, and no new conversion starts.
- R4: A write to address 2 stores the low NPIN write-data bits on `pin_en` and stops any running conversion without starting a new one.
- R5: For a non-reference channel, `samp_en` is high for exactly N = 2 << sel cycles (2, 4, 8 or 16), starting the cycle after the start write. When it falls, `dac_code` holds only its most significant bit set, and `samp_en` stays low for the rest of the search.
- R6: Channel codes 2^CW-2 (low reference) and 2^CW-1 (high reference) never raise `samp_en`. The search starts in the cycle after the start write.
- R7: The search decides one bit per clock from MSB to LSB. It keeps a trial bit when `cmp_in` is 1, which means the input is at or above `dac_code`. `done` rises exactly N+RES cycles after the start write (RES cycles for reference channels), and at that point `busy` is low.
- R8: A read of address 3 returns the result right-justified in `bus_rdata`, with the upper bits zero, on the cycle after the read. During a conversion it returns the previous result.
- R9: `done` is set when the result is written. It is cleared by a start write or by a read of address 3. If a result is written in the same cycle as such a read, the set wins.
- R10: A stop caused by R3 or R4 leaves the result register and `done` unchanged.
- R11: A read of address 0 returns `done` in bit DW-1, `busy` in bit DW-2 and the channel in the low CW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 start/status, 1 control, 2 pin enable, 3 result) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after `bus_rd` |
| ch_sel | output | CW | Channel presented to the analog multiplexer |
| pin_en | output | NPIN | Stored pin-enable bits |
| samp_en | output | 1 | Sampling phase active |
| dac_code | output | RES | Current trial code for the DAC |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion-complete flag |

## Verification
The bench goes after the timing edges first. It counts `samp_en` cycles for every sample-length setting and samples `done` on the exact finishing cycle. A counter that is off by one, or a search that overlaps the sampling phase, shows up as a miscount or a late flag. It then restarts a conversion mid-sample. A design that ignored the restart would report the first channel's code. It also stops conversions through the control and pin-enable addresses, once during sampling and once during the search. A design that restarted, cleared the result or dropped `done` would return a wrong result or flag. Finally, it converts both reference channels, where a design that still sampled would raise `samp_en` and finish late.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } seq_st_t;

  localparam logic [1:0] ADR_START  = 2'd0;
  localparam logic [1:0] ADR_CTRL   = 2'd1;
  localparam logic [1:0] ADR_PINEN  = 2'd2;
  localparam logic [1:0] ADR_RESULT = 2'd3;

  localparam int SEL_W = 2;
endpackage

// File: rtl/sar_smp_timer.sv
module sar_smp_timer #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  output logic             expire
);
  localparam int CNTW = 1 << SEL_W;

  logic [CNTW-1:0] cnt;
  logic [CNTW:0]   n_full;
  logic [CNTW:0]   n_m1;

  always_comb begin
    n_full = {{(CNTW-1){1'b0}}, 2'b10} << sel;
    n_m1   = n_full - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= n_m1[CNTW-1:0];
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init,
  input  logic           step,
  input  logic           cmp,
  output logic [RES-1:0] trial,
  output logic [RES-1:0] trial_nxt,
  output logic           last
);
  localparam int IW = (RES > 1) ? $clog2(RES) : 1;
  localparam logic [IW-1:0] TOP = IW'(RES - 1);

  logic [IW-1:0]  idx;
  logic [RES-1:0] mask;

  always_comb begin
    mask      = {{(RES-1){1'b0}}, 1'b1} << idx;
    trial_nxt = (cmp ? trial : (trial & ~mask)) | (mask >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial <= '0;
      idx   <= '0;
    end else if (init) begin
      trial <= {1'b1, {(RES-1){1'b0}}};
      idx   <= TOP;
    end else if (step) begin
      trial <= trial_nxt;
      if (idx != '0) idx <= idx - 1'b1;
    end
  end

  assign last = (idx == '0);
endmodule

// File: rtl/sar_regif.sv
module sar_regif
  import sar_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NPIN = 8,
  parameter int RES  = 10,
  parameter int CW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic             done,
  input  logic             busy,
  input  logic [CW-1:0]    ch,
  input  logic [RES-1:0]   result,
  output logic [SEL_W-1:0] smp_sel,
  output logic [NPIN-1:0]  pin_en,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_START: begin
        rd_mux[DW-1]   = done;
        rd_mux[DW-2]   = busy;
        rd_mux[CW-1:0] = ch;
      end
      ADR_CTRL:   rd_mux[SEL_W-1:0] = smp_sel;
      ADR_PINEN:  rd_mux[NPIN-1:0]  = pin_en;
      default:    rd_mux[RES-1:0]   = result;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_sel <= '0;
      pin_en  <= '0;
      rdata   <= '0;
    end else begin
      if (wr && addr == ADR_CTRL)  smp_sel <= wdata[SEL_W-1:0];
      if (wr && addr == ADR_PINEN) pin_en  <= wdata[NPIN-1:0];
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES  = 10,
  parameter int CW   = 4,
  parameter int NPIN = 8,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [CW-1:0]   ch_sel,
  output logic [NPIN-1:0] pin_en,
  output logic            samp_en,
  output logic [RES-1:0]  dac_code,
  input  logic            cmp_in,
  output logic            busy,
  output logic            done
);
  localparam logic [CW-1:0] REF_LO = {{(CW-1){1'b1}}, 1'b0};

  seq_st_t          st;
  logic [CW-1:0]    ch_q;
  logic [RES-1:0]   result_q;
  logic             done_q;
  logic [SEL_W-1:0] smp_sel;
  logic             smp_expire;
  logic             apx_last;
  logic [RES-1:0]   trial;
  logic [RES-1:0]   trial_nxt;

  logic start_wr, abort_wr, res_rd, new_ref, apx_init, finish;

  always_comb begin
    start_wr = bus_wr && bus_addr == ADR_START;
    abort_wr = bus_wr && (bus_addr == ADR_CTRL || bus_addr == ADR_PINEN);
    res_rd   = bus_rd && bus_addr == ADR_RESULT;
    new_ref  = bus_wdata[CW-1:0] >= REF_LO;
    apx_init = (start_wr && new_ref) || (st == ST_SAMP && smp_expire);
    finish   = st == ST_CONV && apx_last && !start_wr && !abort_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ch_q     <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (res_rd) done_q <= 1'b0;
      if (start_wr) begin
        ch_q   <= bus_wdata[CW-1:0];
        st     <= new_ref ? ST_CONV : ST_SAMP;
        done_q <= 1'b0;
      end else if (abort_wr) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_SAMP: if (smp_expire) st <= ST_CONV;
          ST_CONV: if (apx_last) begin
            st       <= ST_IDLE;
            result_q <= trial_nxt;
            done_q   <= 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  sar_smp_timer #(.SEL_W(SEL_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (start_wr && !new_ref),
    .sel    (smp_sel),
    .run    (st == ST_SAMP),
    .expire (smp_expire)
  );

  sar_approx #(.RES(RES)) u_apx (
    .clk       (clk),
    .rst       (rst),
    .init      (apx_init),
    .step      (st == ST_CONV && !finish ? 1'b1 : 1'b0),
    .cmp       (cmp_in),
    .trial     (trial),
    .trial_nxt (trial_nxt),
    .last      (apx_last)
  );

  sar_regif #(.DW(DW), .NPIN(NPIN), .RES(RES), .CW(CW)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .done    (done_q),
    .busy    (st != ST_IDLE),
    .ch      (ch_q),
    .result  (result_q),
    .smp_sel (smp_sel),
    .pin_en  (pin_en),
    .rdata   (bus_rdata)
  );

  assign ch_sel   = ch_q;
  assign samp_en  = (st == ST_SAMP);
  assign dac_code = trial;
  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES = 10,
  parameter int CW  = 4,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [1:0]     bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic           samp_en,
  input logic           busy,
  input logic           done,
  input logic [CW-1:0]  ch_sel,
  input logic [RES-1:0] dac_code,
  input logic [RES-1:0] result_q
);
  localparam logic [CW-1:0]  REF_LO = {{(CW-1){1'b1}}, 1'b0};
  localparam logic [RES-1:0] MSB    = {1'b1, {(RES-1){1'b0}}};

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0) |=> (busy && !done && ch_sel == $past(bus_wdata[CW-1:0]))); // R1

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> (!busy && !samp_en)); // R3

  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> ($stable(result_q) && done == $past(done))); // R10

  AST_SAMPLE_TO_MSB: assert property (@(posedge clk) disable iff (rst)
    ($fell(samp_en) && busy) |-> (dac_code == MSB)); // R5

  AST_REF_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[CW-1:0] >= REF_LO) |=> (!samp_en && busy)); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3 && !busy) |=> !done); // R9
endmodule

bind sar_seq sar_seq_chk #(.RES(RES), .CW(CW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .samp_en   (samp_en),
  .busy      (busy),
  .done      (done),
  .ch_sel    (ch_sel),
  .dac_code  (dac_code),
  .result_q  (result_q)
);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  localparam int RES  = 10;
  localparam int CW   = 4;
  localparam int NPIN = 8;
  localparam int DW   = 16;
  localparam int NCH  = 1 << CW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [1:0]      bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic [CW-1:0]   ch_sel;
  logic [NPIN-1:0] pin_en;
  logic            samp_en;
  logic [RES-1:0]  dac_code;
  logic            cmp_in;
  logic            busy;
  logic            done;

  logic [RES-1:0] vin [NCH];
  int n_chk = 0;
  int n_bad = 0;
  logic [RES-1:0] last_res = '0;

  always #2 clk = ~clk;

  sar_seq #(.RES(RES), .CW(CW), .NPIN(NPIN), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_sel(ch_sel), .pin_en(pin_en),
    .samp_en(samp_en), .dac_code(dac_code), .cmp_in(cmp_in), .busy(busy), .done(done)
  );

  function automatic logic [RES-1:0] exp_code(input logic [CW-1:0] c);
    if (c == CW'(NCH - 2)) return '0;
    if (c == CW'(NCH - 1)) return '1;
    return vin[c];
  endfunction

  function automatic bit is_ref(input logic [CW-1:0] c);
    return c >= CW'(NCH - 2);
  endfunction

  always_comb cmp_in = exp_code(ch_sel) >= dac_code;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // start a conversion and follow it to the end; sel must already be programmed
  task automatic convert(input logic [CW-1:0] c, input int sel, input bit do_read);
    int n, t, scnt;
    bit busy_ok;
    logic [DW-1:0] d;
    n = is_ref(c) ? 0 : (2 << sel);
    t = n + RES;
    bus_write(2'd0, DW'(c));
    check(ch_sel == c && !done, "R1 channel load", int'(ch_sel), int'(c));
    scnt = 0; busy_ok = 1'b1;
    for (int k = 0; k < t; k++) begin
      if (samp_en) scnt++;
      if (!busy || done) busy_ok = 1'b0;
      @(negedge clk);
    end
    if (is_ref(c)) check(scnt == 0, "R6 reference skips sampling", scnt, 0);
    else check(scnt == n, "R5 sample length", scnt, n);
    check(busy_ok, "R7 busy until last bit", int'(busy_ok), 1);
    check(done && !busy, "R7 done on exact cycle", int'({done, busy}), 2);
    last_res = exp_code(c);
    if (do_read) begin
      bus_read(2'd3, d);
      check(d == DW'(exp_code(c)), "R8 result value", int'(d), int'(exp_code(c)));
      check(!done, "R9 read clears done", int'(done), 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [CW-1:0] c;
    int sel;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCH; i++) vin[i] = RES'($urandom);
    vin[0] = '0; vin[1] = '1; vin[2] = RES'(1);

    idle(3);
    @(negedge clk) rst = 1'b0;
    check(!busy && !done && !samp_en, "R1 reset idle", int'({busy, done, samp_en}), 0);
    bus_read(2'd3, d);
    check(d == '0, "R8 reset result", int'(d), 0);

    // every sample length on ordinary channels, including extreme codes
    for (int s = 0; s < 4; s++) begin
      bus_write(2'd1, DW'(s));
      bus_read(2'd1, d);
      check(d == DW'(s), "R3 control readback", int'(d), s);
      convert(CW'(s), s, 1'b1);
    end

    // reference channels
    convert(CW'(NCH - 2), 0, 1'b1);
    convert(CW'(NCH - 1), 3, 1'b1);

    // status read during a conversion
    bus_write(2'd1, DW'(3));
    bus_write(2'd0, DW'(5));
    idle(2);
    bus_read(2'd0, d);
    check(d[DW-1] == 1'b0 && d[DW-2] == 1'b1 && d[CW-1:0] == 4'd5,
          "R11 status fields", int'(d), (1 << (DW - 2)) | 5);
    // result readable mid-conversion
    bus_read(2'd3, d);
    check(d == DW'(last_res), "R8 old result during run", int'(d), int'(last_res));
    // abort by control write during sampling
    bus_write(2'd1, DW'(3));
    check(!busy && !samp_en, "R3 control write stops", int'({busy, samp_en}), 0);
    idle(40);
    check(!busy && !done, "R3 no restart after stop", int'({busy, done}), 0);
    bus_read(2'd3, d);
    check(d == DW'(last_res), "R10 result kept after stop", int'(d), int'(last_res));

    // done kept through a stop
    bus_write(2'd1, DW'(0));
    convert(4'd6, 0, 1'b0);
    bus_write(2'd1, DW'(0));
    check(done, "R10 done kept by stop", int'(done), 1);
    bus_read(2'd3, d);
    check(d == DW'(vin[6]), "R8 result after stop", int'(d), int'(vin[6]));

    // abort by pin-enable write during the search
    bus_write(2'd0, DW'(7));
    idle(4);
    check(busy && !samp_en, "R5 in search phase", int'({busy, samp_en}), 2);
    bus_write(2'd2, DW'(8'hA5));
    check(!busy && pin_en == 8'hA5, "R4 pin write stops", int'({busy, pin_en}), 8'hA5);
    idle(RES + 5);
    check(!busy && !done, "R4 no restart", int'({busy, done}), 0);
    bus_read(2'd3, d);
    check(d == DW'(vin[6]), "R10 result kept after pin stop", int'(d), int'(vin[6]));

    // restart mid-sample on a different channel
    bus_write(2'd1, DW'(2));
    bus_write(2'd0, DW'(8));
    idle(3);
    convert(4'd9, 2, 1'b1);
    bus_write(2'd0, DW'(NCH - 1));
    idle(2);
    convert(4'd3, 2, 1'b1);  // R2 restart during search

    // random mix
    for (int it = 0; it < 40; it++) begin
      c = CW'($urandom);
      sel = int'($urandom % 4);
      if (!is_ref(c)) vin[c] = RES'($urandom);
      bus_write(2'd1, DW'(sel));
      convert(c, sel, ($urandom % 4) != 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule